// File: doc/BRIEF.md
# Binary Field Squarer for GF(2^233)

This block squares one element of the binary field GF(2^233). The field is built on the trinomial x^233 + x^74 + 1. The element arrives in a 256-bit word, and the reduced result leaves in a 256-bit word. Squaring a polynomial over GF(2) produces no cross terms. The block therefore forms the unreduced square by moving each input bit i to bit 2i and leaving every odd position zero. This uses wiring only, with no multiplier. The 465-bit square is then brought back below degree 233 in two folding passes, using x^233 = x^74 + 1. The result is equal to the product of a general field multiplier whose two operands are the same value.

A small state machine runs one operation at a time. It has four states:
- IDLE: waiting for a request.
- EXPAND: registers the bit-spread square.
- REDUCE: registers the folded result.
- FINISH: raises done for one cycle.

The transitions are:
- accept: IDLE to EXPAND on start.
- spread: EXPAND to REDUCE, always taken.
- fold: REDUCE to FINISH, always taken.
- retire: FINISH to IDLE when start is low.
- chain: FINISH to EXPAND when start is high.

A request can therefore be issued in the same cycle as the previous done.

Top module: `gf233_squarer`

## Requirements
- R1: While reset is held and in the first cycle after it, done is 0 and result is all zeros.
- R2: When done is high, result[232:0] equals the square of operand[232:0] reduced modulo x^233 + x^74 + 1. Bit i of the vector is the coefficient of x^i. The operand is the one captured when start was accepted.
- R3: result[255:233] is always zero.
- R4: operand[255:233] has no effect on the result.
- R5: done is high for exactly one cycle. That cycle is the third clock cycle after the cycle in which start was accepted.
- R6: start is accepted only in IDLE or in the done cycle. A start that arrives during the two busy cycles is ignored: it neither changes the pending result nor causes an extra done.
- R7: result holds its value from one done cycle until the done cycle of the next accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a squaring of operand |
| operand | input | 256 | Field element; bits 232:0 used |
| done | output | 1 | One-cycle completion pulse |
| result | output | 256 | Reduced square; bits 255:233 zero |

## Verification
Two events can meet in one cycle: the done pulse of one operation and the acceptance of the next start. The bench provokes this by raising start with a fresh operand in exactly the cycle where done is high. It then checks two things. First, the earlier square stays on result through the two busy cycles that follow. Second, a single new done appears three cycles later, carrying the square of the second operand. The reference for every square is a bit-serial multiply-and-reduce of the operand by itself, written independently of the bit-spreading datapath.

// File: rtl/gf233_sq_pkg.sv
package gf233_sq_pkg;
    localparam int FIELD_W = 233;
    localparam int TAP     = 74;
    localparam int REG_W   = 256;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_EXPAND = 2'd1,
        S_REDUCE = 2'd2,
        S_FINISH = 2'd3
    } sq_state_e;
endpackage

// File: rtl/gf233_spread.sv
// Squaring over GF(2): coefficient i moves to position 2i, odd positions are zero.
module gf233_spread #(
    parameter int IN_W = 233
) (
    input  logic [IN_W-1:0]   a,
    output logic [2*IN_W-1:0] y
);
    for (genvar i = 0; i < IN_W; i++) begin : g_bit
        assign y[2*i]   = a[i];
        assign y[2*i+1] = 1'b0;
    end
endmodule

// File: rtl/gf233_fold.sv
// Two-pass reduction by x^W = x^TAP + 1 (valid while 2*TAP <= W).
module gf233_fold #(
    parameter int W   = 233,
    parameter int TAP = 74
) (
    input  logic [2*W-1:0] wide,
    output logic [W-1:0]   y
);
    localparam int EXT = W + TAP;

    logic [W-1:0]   hi1;
    logic [EXT-1:0] pass1;
    logic [TAP-1:0] hi2;

    always_comb begin
        hi1   = wide[2*W-1:W];
        pass1 = {{TAP{1'b0}}, wide[W-1:0]}
              ^ {{TAP{1'b0}}, hi1}
              ^ ({{TAP{1'b0}}, hi1} << TAP);
        hi2   = pass1[EXT-1:W];
        y     = pass1[W-1:0]
              ^ {{(W-TAP){1'b0}}, hi2}
              ^ ({{(W-TAP){1'b0}}, hi2} << TAP);
    end
endmodule

// File: rtl/gf233_squarer.sv
module gf233_squarer
    import gf233_sq_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int TW = TAP,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] operand,
    output logic          done,
    output logic [RW-1:0] result
);
    localparam int SQ_W  = 2 * FW;
    localparam int PAD_W = RW - FW;

    sq_state_e state_q, state_d;

    logic            accept, load_sq, load_res;
    logic [FW-1:0]   op_q;
    logic [SQ_W-1:0] sq_d, sq_q;
    logic [FW-1:0]   red_d, res_q;
    logic            unused_op_hi;

    assign unused_op_hi = ^operand[RW-1:FW];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept, spread, fold, retire, chain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_EXPAND;
            S_EXPAND: state_d = S_REDUCE;
            S_REDUCE: state_d = S_FINISH;
            S_FINISH: state_d = start ? S_EXPAND : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs and datapath enables per state
    always_comb begin
        done     = 1'b0;
        accept   = 1'b0;
        load_sq  = 1'b0;
        load_res = 1'b0;
        unique case (state_q)
            S_IDLE:   accept = start;
            S_EXPAND: load_sq = 1'b1;
            S_REDUCE: load_res = 1'b1;
            S_FINISH: begin
                done   = 1'b1;
                accept = start;
            end
            default: ;
        endcase
    end

    gf233_spread #(.IN_W(FW)) u_spread (
        .a (op_q),
        .y (sq_d)
    );

    gf233_fold #(.W(FW), .TAP(TW)) u_fold (
        .wide (sq_q),
        .y    (red_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            sq_q  <= '0;
            res_q <= '0;
        end else begin
            if (accept)   op_q  <= operand[FW-1:0];
            if (load_sq)  sq_q  <= sq_d;
            if (load_res) res_q <= red_d;
        end
    end

    assign result = {{PAD_W{1'b0}}, res_q};
endmodule

// File: rtl/gf233_squarer_chk.sv
module gf233_squarer_chk
    import gf233_sq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [REG_W-1:0] result,
    input sq_state_e        state
);
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (state == S_IDLE || state == S_FINISH)) |=> !done ##1 !done ##1 done);

    assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXPAND) |=> (state == S_REDUCE));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        result[REG_W-1:FIELD_W] == '0);
endmodule

bind gf233_squarer gf233_squarer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .result (result),
    .state  (state_q)
);

// File: tb/gf233_squarer_tb.sv
module gf233_squarer_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] operand = '0;
    logic         done;
    logic [255:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    gf233_squarer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .operand (operand),
        .done    (done),
        .result  (result)
    );

    // Independent reference: bit-serial a*a mod x^233 + x^74 + 1.
    function automatic logic [255:0] ref_sq(input logic [255:0] op);
        logic [232:0] a;
        logic [233:0] r;
        logic [233:0] poly;
        a    = op[232:0];
        r    = '0;
        poly = '0;
        poly[233] = 1'b1;
        poly[74]  = 1'b1;
        poly[0]   = 1'b1;
        for (int i = 232; i >= 0; i--) begin
            r = {r[232:0], 1'b0};
            if (r[233]) r = r ^ poly;
            if (a[i]) r = r ^ {1'b0, a};
        end
        return {23'd0, r[232:0]};
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", {255'd0, done}, '0);
        chk(result == '0, "R1 result in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", {255'd0, done}, '0);
        chk(result == '0, "R1 result after reset", result, '0);
    endtask

    // one operation from IDLE, checks latency, value, upper bits, hold
    task automatic run_sq(input logic [255:0] op, input string req);
        logic [255:0] exp;
        exp = ref_sq(op);
        @(negedge clk);
        operand = op;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R5 busy1", {255'd0, done}, '0);
        @(negedge clk);
        chk(done == 1'b0, "R5 busy2", {255'd0, done}, '0);
        @(negedge clk);
        chk(done == 1'b1, "R5 done", {255'd0, done}, 256'd1);
        chk(result == exp, req, result, exp);
        chk(result[255:233] == '0, "R3 upper zero", result, exp);
        @(negedge clk);
        chk(done == 1'b0, "R5 single pulse", {255'd0, done}, '0);
        chk(result == exp, "R7 hold", result, exp);
    endtask

    task automatic test_directed();
        logic [255:0] v;
        run_sq('0, "R2 zero");
        run_sq(256'd1, "R2 one");
        v = '0; v[232] = 1'b1;
        run_sq(v, "R2 top bit double fold");
        v = '0; v[117] = 1'b1;
        run_sq(v, "R2 first fold boundary");
        v = '0; v[232:0] = '1;
        run_sq(v, "R2 all ones");
        v = '0; v[232:200] = '1; v[5] = 1'b1;
        run_sq(v, "R2 high cluster");
    endtask

    task automatic test_random();
        for (int n = 0; n < 24; n++) begin
            logic [255:0] v;
            v = rnd256();
            v[255:233] = '0;
            run_sq(v, "R2 random");
        end
    endtask

    task automatic test_upper_ignored();
        logic [255:0] v;
        v = rnd256();
        v[255:233] = 23'h7fffff;
        run_sq(v, "R4 upper bits set");
        v[255:233] = 23'h2a5a5a;
        run_sq(v, "R4 upper bits pattern");
    endtask

    // start in the done cycle of the previous operation
    task automatic test_chain();
        logic [255:0] a, b, ea, eb;
        a = rnd256(); a[255:233] = '0;
        b = rnd256(); b[255:233] = '0;
        ea = ref_sq(a);
        eb = ref_sq(b);
        @(negedge clk);
        operand = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R5 chain first done", {255'd0, done}, 256'd1);
        chk(result == ea, "R2 chain first value", result, ea);
        operand = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R5 chain busy1", {255'd0, done}, '0);
        chk(result == ea, "R7 chain hold1", result, ea);
        @(negedge clk);
        chk(done == 1'b0, "R5 chain busy2", {255'd0, done}, '0);
        chk(result == ea, "R7 chain hold2", result, ea);
        @(negedge clk);
        chk(done == 1'b1, "R6 chain second done", {255'd0, done}, 256'd1);
        chk(result == eb, "R6 chain second value", result, eb);
        @(negedge clk);
        chk(done == 1'b0, "R5 chain pulse end", {255'd0, done}, '0);
    endtask

    // start held during the busy cycles must be ignored
    task automatic test_busy_ignore();
        logic [255:0] a, b, ea;
        a = rnd256(); a[255:233] = '0;
        b = ~a;       b[255:233] = '0;
        ea = ref_sq(a);
        @(negedge clk);
        operand = a; start = 1'b1;
        @(negedge clk);
        operand = b;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R6 busy done", {255'd0, done}, 256'd1);
        chk(result == ea, "R6 busy start ignored", result, ea);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(done == 1'b0, "R6 no extra done", {255'd0, done}, '0);
            chk(result == ea, "R7 idle hold", result, ea);
        end
    endtask

    initial begin
        test_reset();
        test_directed();
        test_random();
        test_upper_ignored();
        test_chain();
        test_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule